// File: doc/BRIEF.md
# Dual-Channel Phase-Accumulator Clock Synthesizer

This block synthesizes clock-enable style outputs from one fast master clock (204.8 MHz in the target system) by numerical control. A tuning word is added to a 32-bit phase accumulator on every master-clock tick. The accumulator's top bit is the synthesized clock, so the output frequency is the master frequency times the tuning word divided by 2^32. A tuning word of zero freezes the output.

Two accumulators share the tuning word. The forward channel drives the output-clock path. The feedback channel drives the locking path. The feedback channel can also take a one-time phase offset through a load strobe. Because the offset is added only once, both channels run at exactly the same frequency and differ only in phase.

For each channel the block exposes the full phase word, a rising-edge flag and a short fractional code. The fractional code is taken from the bits just below the top bit at each top-bit transition, and it tells a downstream edge-placement stage how far past the ideal edge the master tick landed.

Top module: `dual_phase_synth`

## Requirements
- R1: On every master-clock cycle out of reset, `fwd_phase` becomes its previous value plus `tune_word`, modulo 2^32.
- R2: `fwd_clk` equals bit 31 of `fwd_phase`. With accumulators starting from zero and a constant `tune_word` T, the clock has T*C/2^32 rising edges over C cycles, counted whole.
- R3: While `tune_word` is zero, both phase words and both clock outputs stay unchanged from cycle to cycle.
- R4: `fbk_phase` advances by the same `tune_word` each cycle. In any cycle without `offset_load`, the difference `fbk_phase - fwd_phase` (mod 2^32) does not change.
- R5: In a cycle with `offset_load` high, `offset_word` is added to `fbk_phase` once, on top of the tuning increment. Changes to `offset_word` while `offset_load` is low have no effect on either channel.
- R6: While `rst` is high at a clock edge, both phase words are cleared to zero. Both clocks, both edge flags and both fractional codes then read zero, so the channels are phase-aligned.
- R7: `fwd_edge` and `fbk_edge` are high for exactly one cycle: the cycle in which the corresponding clock is high after having been low in the previous cycle.
- R8: In a cycle where a channel's bit 31 changes in either direction, its fractional code output equals bits 30:27 of that channel's phase word. The code holds that value until the next transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 32 | Per-cycle phase increment shared by both channels |
| offset_word | input | 32 | Phase offset applied to the feedback channel on load |
| offset_load | input | 1 | Adds `offset_word` to the feedback accumulator this cycle |
| fwd_clk | output | 1 | Forward synthesized clock (accumulator top bit) |
| fwd_edge | output | 1 | One-cycle flag on a forward rising transition |
| fwd_frac | output | 4 | Forward sub-tick edge-position code |
| fwd_phase | output | 32 | Forward accumulator state |
| fbk_clk | output | 1 | Feedback synthesized clock |
| fbk_edge | output | 1 | One-cycle flag on a feedback rising transition |
| fbk_frac | output | 4 | Feedback sub-tick edge-position code |
| fbk_phase | output | 32 | Feedback accumulator state |

## Verification
Every phase word is a register, so a tuning or offset change applied before a clock edge is visible on `*_phase` and `*_clk` right after that edge. The edge flags and fractional codes follow the same edge with no extra delay, because they come from the new accumulator value compared with a registered copy of the previous top bit. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands exactly one edge after its stimulus. Its expected phases come from products of tune word and elapsed cycle count, which gives expected clock-edge totals and fractional codes at known cycle numbers.

// File: rtl/dual_phase_synth.sv
module dual_phase_synth #(
  parameter int ACC_W  = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  tune_word,
  input  logic [ACC_W-1:0]  offset_word,
  input  logic              offset_load,
  output logic              fwd_clk,
  output logic              fwd_edge,
  output logic [CODE_W-1:0] fwd_frac,
  output logic [ACC_W-1:0]  fwd_phase,
  output logic              fbk_clk,
  output logic              fbk_edge,
  output logic [CODE_W-1:0] fbk_frac,
  output logic [ACC_W-1:0]  fbk_phase
);
  localparam int TOP     = ACC_W - 1;
  localparam int CODE_HI = TOP - 1;
  localparam int CODE_LO = TOP - CODE_W;

  logic [ACC_W-1:0]  fwd_acc, fbk_acc;
  logic [ACC_W-1:0]  fbk_add;
  logic              fwd_top_q, fbk_top_q;
  logic [CODE_W-1:0] fwd_code_q, fbk_code_q;
  logic              fwd_flip, fbk_flip;

  assign fbk_add = offset_load ? offset_word : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_acc <= '0;
      fbk_acc <= '0;
    end else begin
      fwd_acc <= fwd_acc + tune_word;
      fbk_acc <= fbk_acc + tune_word + fbk_add;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_top_q  <= 1'b0;
      fbk_top_q  <= 1'b0;
      fwd_code_q <= '0;
      fbk_code_q <= '0;
    end else begin
      fwd_top_q <= fwd_acc[TOP];
      fbk_top_q <= fbk_acc[TOP];
      if (fwd_flip) fwd_code_q <= fwd_acc[CODE_HI:CODE_LO];
      if (fbk_flip) fbk_code_q <= fbk_acc[CODE_HI:CODE_LO];
    end
  end

  assign fwd_flip  = fwd_acc[TOP] ^ fwd_top_q;
  assign fbk_flip  = fbk_acc[TOP] ^ fbk_top_q;

  assign fwd_clk   = fwd_acc[TOP];
  assign fbk_clk   = fbk_acc[TOP];
  assign fwd_edge  = fwd_acc[TOP] & ~fwd_top_q;
  assign fbk_edge  = fbk_acc[TOP] & ~fbk_top_q;
  assign fwd_frac  = fwd_flip ? fwd_acc[CODE_HI:CODE_LO] : fwd_code_q;
  assign fbk_frac  = fbk_flip ? fbk_acc[CODE_HI:CODE_LO] : fbk_code_q;
  assign fwd_phase = fwd_acc;
  assign fbk_phase = fbk_acc;

  // R1
  fwd_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fwd_phase == $past(fwd_phase) + $past(tune_word));

  // R3
  zero_tune_static_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tune_word) == '0 && !$past(offset_load))
      |-> ($stable(fwd_phase) && $stable(fbk_phase)));

  // R4
  freq_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !offset_load |=> (fbk_phase - fwd_phase) == $past(fbk_phase - fwd_phase));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (fwd_phase == '0 && fbk_phase == '0));

  // R7
  fwd_edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_edge |=> !fwd_edge);

  // R7
  fbk_edge_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (fbk_edge == (fbk_clk && !$past(fbk_clk))));

  // R8
  frac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(fwd_clk)) |-> $stable(fwd_frac));
endmodule

// File: tb/dual_phase_synth_tb.sv
module dual_phase_synth_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tune_word = '0;
  logic [31:0] offset_word = '0;
  logic        offset_load = 1'b0;
  logic        fwd_clk, fwd_edge, fbk_clk, fbk_edge;
  logic [3:0]  fwd_frac, fbk_frac;
  logic [31:0] fwd_phase, fbk_phase;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_phase_synth dut_i (
    .clk(clk), .rst(rst), .tune_word(tune_word), .offset_word(offset_word),
    .offset_load(offset_load), .fwd_clk(fwd_clk), .fwd_edge(fwd_edge),
    .fwd_frac(fwd_frac), .fwd_phase(fwd_phase), .fbk_clk(fbk_clk),
    .fbk_edge(fbk_edge), .fbk_frac(fbk_frac), .fbk_phase(fbk_phase)
  );

  // {tune, cycles, expected rising edges}
  localparam logic [95:0] VEC [5] = '{
    {32'h1000_0000, 32'd64, 32'd4},
    {32'h2000_0000, 32'd64, 32'd8},
    {32'h3000_0000, 32'd64, 32'd12},
    {32'h8000_0000, 32'd64, 32'd32},
    {32'h0000_0000, 32'd64, 32'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    // R6 reset state
    @(posedge clk);
    @(negedge clk);
    chk("R6 fwd_phase", fwd_phase, 32'h0);
    chk("R6 fbk_phase", fbk_phase, 32'h0);
    chk("R6 clks/edges", {28'h0, fwd_clk, fbk_clk, fwd_edge, fbk_edge}, 32'h0);
    chk("R6 fracs", {24'h0, fwd_frac, fbk_frac}, 32'h0);

    // R1 R2 R4 table of tuning words
    foreach (VEC[v]) begin
      logic [31:0] t, c, e;
      int nf, nb;
      {t, c, e} = VEC[v];
      nf = 0;
      nb = 0;
      tune_word = t;
      do_reset();
      for (int k = 0; k < int'(c); k++) begin
        @(negedge clk);
        if (fwd_edge) nf++;
        if (fbk_edge) nb++;
      end
      chk("R2 fwd rising edges", nf, e);
      chk("R7 fbk rising edges", nb, e);
      chk("R1 fwd_phase", fwd_phase, t * c);
      chk("R4 fbk equals fwd", fbk_phase, t * c);
      chk("R2 fwd_clk is top bit", {31'h0, fwd_clk}, {31'h0, fwd_phase[31]});
    end

    // R8 fractional code at transitions
    tune_word = 32'h3000_0000;
    do_reset();
    @(negedge clk);
    @(negedge clk);
    chk("R7 no edge before crossing", {31'h0, fwd_edge}, 32'h0);
    @(negedge clk);
    chk("R7 edge at crossing", {31'h0, fwd_edge}, 32'h1);
    chk("R8 frac at rise", {28'h0, fwd_frac}, 32'h2);
    @(negedge clk);
    chk("R7 edge one cycle", {31'h0, fwd_edge}, 32'h0);
    chk("R8 frac held", {28'h0, fwd_frac}, 32'h2);
    @(negedge clk);
    @(negedge clk);
    chk("R8 fall clk", {31'h0, fwd_clk}, 32'h0);
    chk("R8 frac at fall", {28'h0, fwd_frac}, 32'h4);

    // R5 offset load and ignore
    tune_word = 32'h0;
    do_reset();
    offset_word = 32'h8000_0000;
    offset_load = 1'b1;
    @(negedge clk);
    offset_load = 1'b0;
    chk("R5 fbk_phase after load", fbk_phase, 32'h8000_0000);
    chk("R5 fwd untouched", fwd_phase, 32'h0);
    chk("R7 fbk edge on load", {31'h0, fbk_edge}, 32'h1);
    @(negedge clk);
    chk("R7 fbk edge clears", {31'h0, fbk_edge}, 32'h0);
    chk("R3 static at zero tune", fbk_phase, 32'h8000_0000);
    offset_word = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk("R5 offset_word ignored", fbk_phase, 32'h8000_0000);
    chk("R3 fwd static", fwd_phase, 32'h0);
    tune_word = 32'h0100_0000;
    repeat (10) @(negedge clk);
    chk("R4 phase difference", fbk_phase - fwd_phase, 32'h8000_0000);
    chk("R1 fwd after ten steps", fwd_phase, 32'h0A00_0000);

    done = 1;
    finish_run();
  end
endmodule